// File: doc/BRIEF.md
# Two-Level Page-Table Walker

This block resolves a translation miss by reading a two-level page table from physical memory. On a miss request it takes the virtual address, the kind of access and the root of the current table. It reads the first-level entry, follows that entry to the second-level table, and reads the leaf entry. The walk then ends in one of three ways: a refill of the TLB with a physical page number and permission bits, a page fault, or a refill together with a protection fault. The page-table reads use physical addresses and are never translated themselves.

The walker handles one miss at a time. It keeps its request input not ready while a walk is in progress. Its memory side is a request/response read port that may stall the request for any number of cycles and may return data after any delay. The TLB array and the fault handling in software sit outside this block.

Top module: `pt_walker`

## Requirements
- R1: One cycle after a request is accepted, the walker issues a memory read at `{ptbr[31:12], 12'h000} + va[31:22]*4`. The low 12 bits of `ptbr` are ignored.
- R2: When the first-level entry has bit 0 set, the second read goes to `{entry[31:12], 12'h000} + va[21:12]*4`. This read is issued only after the first response has arrived.
- R3: A first-level entry with bit 0 clear ends the walk with `fault_page` high and `tlb_fill` low, and no second memory read is made.
- R4: A second-level entry with bit 0 clear ends the walk with `fault_page` high, `fault_prot` low and `tlb_fill` low.
- R5: A second-level entry with bit 0 set ends the walk with `tlb_fill` high, `done_ppn` equal to entry bits 31..12, and `done_perm` equal to entry bits 3..1 (bit 0 = read, bit 1 = write, bit 2 = execute). Entry bits 11..4 have no effect.
- R6: `req_acc` is a mask with bit 0 = read, bit 1 = write and bit 2 = execute. After a successful walk, `fault_prot` is high exactly when a requested bit is missing from `done_perm`. `tlb_fill` stays high in that case and `fault_page` stays low.
- R7: `req_ready` equals `!busy`. `busy` stays high from the cycle after acceptance up to and including the single `done` cycle. A request offered while busy is not taken.
- R8: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen, and then falls. A response is accepted after any number of wait cycles.
- R9: During and straight after reset, `busy`, `done` and `mem_req_valid` are low and `req_ready` is high.
- R10: `fault_page`, `fault_prot` and `tlb_fill` are high only in the `done` cycle, and `fault_page` and `fault_prot` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Virtual address that missed |
| req_acc | input | 3 | Access mask: read, write, execute |
| ptbr | input | 32 | Root table base; bits 31..12 used |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Physical word address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| done_ppn | output | 20 | Physical page number for the refill |
| done_perm | output | 3 | Permission bits for the refill |
| tlb_fill | output | 1 | Write the refill into the TLB |
| fault_page | output | 1 | Nonexistent or non-resident page |
| fault_prot | output | 1 | Access denied by permissions |

## Verification
The TLB refill and the protection fault can both occur in the same `done` cycle. A successful walk still writes the refill, and the permission check can reject the access in that same cycle. The bench provokes this by sweeping every one-hot access mask against every leaf permission pattern the table generator produces. Each `done` cycle is then judged on both `tlb_fill` and `fault_prot` against values the bench derives from the entry it served. A second overlap tested is a new request arriving while a walk is in progress: the bench holds a different request valid from the first cycle of each walk until `done`, and confirms that the walk result belongs to the original address and that the walker is idle afterwards.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned PERM_W = 3;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_L1_REQ  = 3'd1,
    S_L1_WAIT = 3'd2,
    S_L2_REQ  = 3'd3,
    S_L2_WAIT = 3'd4,
    S_DONE    = 3'd5
  } walk_state_t;

  // A requested right that the entry lacks denies the access.
  function automatic logic access_denied(input logic [PERM_W-1:0] want,
                                         input logic [PERM_W-1:0] have);
    return |(want & ~have);
  endfunction
endpackage

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic rsp_entry_ok,
  output logic walk_start,
  output logic l1_take,
  output logic l2_take,
  output logic sel_l2,
  output logic mem_req_valid,
  output logic busy,
  output logic done
);
  walk_state_t state_q, state_d;

  assign walk_start    = (state_q == S_IDLE) && req_valid;
  assign l1_take       = (state_q == S_L1_WAIT) && mem_rsp_valid;
  assign l2_take       = (state_q == S_L2_WAIT) && mem_rsp_valid;
  assign sel_l2        = (state_q == S_L2_REQ);
  assign mem_req_valid = (state_q == S_L1_REQ) || (state_q == S_L2_REQ);
  assign busy          = (state_q != S_IDLE);
  assign done          = (state_q == S_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (req_valid) state_d = S_L1_REQ;
      S_L1_REQ:  if (mem_req_ready) state_d = S_L1_WAIT;
      S_L1_WAIT: if (mem_rsp_valid) state_d = rsp_entry_ok ? S_L2_REQ : S_DONE;
      S_L2_REQ:  if (mem_req_ready) state_d = S_L2_WAIT;
      S_L2_WAIT: if (mem_rsp_valid) state_d = S_DONE;
      S_DONE:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/ptw_addr.sv
module ptw_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              walk_start,
  input  logic [ADDR_W-1:0] req_va,
  input  logic [ADDR_W-1:0] ptbr,
  input  logic              l1_take,
  input  logic [ADDR_W-1:0] rsp_data,
  input  logic              sel_l2,
  output logic [ADDR_W-1:0] entry_addr
);
  localparam int unsigned BASE_W = ADDR_W - OFF_W;
  localparam int unsigned WORD_B = 2;
  localparam int unsigned PAD_W  = ADDR_W - IDX_W - WORD_B;

  logic [IDX_W-1:0]  idx1_q, idx2_q;
  logic [BASE_W-1:0] root_q, next_q;

  // Table base plus index scaled to a word offset.
  function automatic logic [ADDR_W-1:0] table_slot(input logic [BASE_W-1:0] base,
                                                   input logic [IDX_W-1:0] idx);
    return {base, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, idx, {WORD_B{1'b0}}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx1_q <= '0;
      idx2_q <= '0;
      root_q <= '0;
      next_q <= '0;
    end else begin
      if (walk_start) begin
        idx1_q <= req_va[ADDR_W-1 -: IDX_W];
        idx2_q <= req_va[OFF_W +: IDX_W];
        root_q <= ptbr[ADDR_W-1:OFF_W];
      end
      if (l1_take) next_q <= rsp_data[ADDR_W-1:OFF_W];
    end
  end

  assign entry_addr = sel_l2 ? table_slot(next_q, idx2_q) : table_slot(root_q, idx1_q);
endmodule

// File: rtl/ptw_result.sv
module ptw_result
  import ptw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    walk_start,
  input  logic [PERM_W-1:0]       req_acc,
  input  logic                    l1_take,
  input  logic                    l2_take,
  input  logic [ADDR_W-1:0]       rsp_data,
  output logic [ADDR_W-OFF_W-1:0] res_ppn,
  output logic [PERM_W-1:0]       res_perm,
  output logic                    res_fpage,
  output logic                    res_fprot
);
  logic [PERM_W-1:0] acc_q;
  logic              entry_ok;
  logic [PERM_W-1:0] entry_perm;

  assign entry_ok   = rsp_data[0];
  assign entry_perm = rsp_data[PERM_W:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      res_ppn   <= '0;
      res_perm  <= '0;
      res_fpage <= 1'b0;
      res_fprot <= 1'b0;
    end else if (walk_start) begin
      acc_q     <= req_acc;
      res_ppn   <= '0;
      res_perm  <= '0;
      res_fpage <= 1'b0;
      res_fprot <= 1'b0;
    end else if (l1_take) begin
      res_fpage <= !entry_ok;
    end else if (l2_take) begin
      res_fpage <= !entry_ok;
      if (entry_ok) begin
        res_ppn   <= rsp_data[ADDR_W-1:OFF_W];
        res_perm  <= entry_perm;
        res_fprot <= access_denied(acc_q, entry_perm);
      end
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_va,
  input  logic [PERM_W-1:0]       req_acc,
  input  logic [ADDR_W-1:0]       ptbr,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [ADDR_W-1:0]       mem_rsp_data,
  output logic                    busy,
  output logic                    done,
  output logic [ADDR_W-OFF_W-1:0] done_ppn,
  output logic [PERM_W-1:0]       done_perm,
  output logic                    tlb_fill,
  output logic                    fault_page,
  output logic                    fault_prot
);
  logic walk_start, l1_take, l2_take, sel_l2;
  logic res_fpage, res_fprot;

  ptw_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .rsp_entry_ok(mem_rsp_data[0]),
    .walk_start(walk_start), .l1_take(l1_take), .l2_take(l2_take),
    .sel_l2(sel_l2), .mem_req_valid(mem_req_valid), .busy(busy), .done(done)
  );

  ptw_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_addr (
    .clk(clk), .rst_n(rst_n), .walk_start(walk_start), .req_va(req_va),
    .ptbr(ptbr), .l1_take(l1_take), .rsp_data(mem_rsp_data),
    .sel_l2(sel_l2), .entry_addr(mem_req_addr)
  );

  ptw_result #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_res (
    .clk(clk), .rst_n(rst_n), .walk_start(walk_start), .req_acc(req_acc),
    .l1_take(l1_take), .l2_take(l2_take), .rsp_data(mem_rsp_data),
    .res_ppn(done_ppn), .res_perm(done_perm),
    .res_fpage(res_fpage), .res_fprot(res_fprot)
  );

  assign req_ready  = !busy;
  assign fault_page = done && res_fpage;
  assign fault_prot = done && res_fprot;
  assign tlb_fill   = done && !res_fpage;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic              tlb_fill,
  input logic              fault_page,
  input logic              fault_prot,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [ADDR_W-1:0] mem_rsp_data,
  input logic              walk_start,
  input logic              l1_take,
  input logic              l2_take
);
  a_r1_read_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> mem_req_valid);
  a_r3_l1_invalid_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_take && !mem_rsp_data[0]) |=> (done && fault_page && !mem_req_valid));
  a_r5_leaf_completes: assert property (@(posedge clk) disable iff (!rst_n)
    l2_take |=> done);
  a_r7_not_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  a_r10_flags_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(tlb_fill || fault_page || fault_prot));
  a_r10_faults_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_page && fault_prot));
endmodule

bind pt_walker ptw_checker #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [2:0]  req_acc = '0;
  logic [31:0] ptbr = 32'h0010_0ABC;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        busy, done, tlb_fill, fault_page, fault_prot;
  logic [19:0] done_ppn;
  logic [2:0]  done_perm;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pt_walker i_pt_walker (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] l1_word(input int i1);
    logic v = (i1 % 4) != 3;
    return {20'(32'h200 + i1), 8'hA5, 3'b101, v};
  endfunction

  function automatic logic [31:0] l2_word(input int i1, input int i2);
    logic v = (i2 % 5) != 0;
    return {20'(i1 * 7 + i2 * 13 + 5), 8'h5A, 3'((i1 + i2) % 8), v};
  endfunction

  task automatic serve(input logic [31:0] exp_addr, input logic [31:0] word,
                       input int dly, input int rdly, input string tag);
    chk(mem_req_valid === 1'b1, {tag, " read issued"}, 32'(mem_req_valid), 1);
    chk(mem_req_addr === exp_addr, {tag, " read address"}, mem_req_addr, exp_addr);
    repeat (dly) begin
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr === exp_addr, "R8 request held", mem_req_addr, exp_addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(mem_req_valid === 1'b0, "R8 request drops", 32'(mem_req_valid), 0);
    repeat (rdly) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = word;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'hDEAD_BEEF;
  endtask

  task automatic walk(input int i1, input int i2, input logic [2:0] acc, input int n);
    logic [31:0] va = {10'(i1), 10'(i2), 12'((i1 * 31 + i2) & 12'hFFF)};
    logic [31:0] w1 = l1_word(i1);
    logic [31:0] w2 = l2_word(i1, i2);
    logic [2:0]  perm = w2[3:1];
    logic        prot;
    @(negedge clk);
    chk(req_ready === 1'b1, "R7 ready when idle", 32'(req_ready), 1);
    req_valid = 1'b1; req_va = va; req_acc = acc;
    @(negedge clk);
    // Different request held valid during the walk; it must not be taken.
    req_va = va ^ 32'hFFC0_0000; req_acc = 3'b111;
    chk(busy && !req_ready, "R7 busy after accept", {busy, req_ready}, 32'b10);
    serve(32'h0010_0000 + 32'(i1) * 4, w1, n % 3, n % 4, "R1");
    if (!w1[0]) begin
      chk(done && fault_page && !fault_prot && !tlb_fill, "R3 l1 page fault",
          {done, fault_page, fault_prot, tlb_fill}, 32'b1100);
      chk(mem_req_valid === 1'b0, "R3 no second read", 32'(mem_req_valid), 0);
    end else begin
      chk(!done, "R2 walk continues", 32'(done), 0);
      serve(32'((32'h200 + i1) << 12) + 32'(i2) * 4, w2, (n + 1) % 3, (n + 2) % 4, "R2");
      if (!w2[0]) begin
        chk(done && fault_page && !fault_prot && !tlb_fill, "R4 l2 page fault",
            {done, fault_page, fault_prot, tlb_fill}, 32'b1100);
      end else begin
        prot = |(acc & ~perm);
        chk(done && tlb_fill && !fault_page, "R5 refill", {done, tlb_fill, fault_page}, 32'b110);
        chk(done_ppn === w2[31:12], "R5 ppn", 32'(done_ppn), 32'(w2[31:12]));
        chk(done_perm === perm, "R5 perm", 32'(done_perm), 32'(perm));
        chk(fault_prot === prot, "R6 protection", 32'(fault_prot), 32'(prot));
      end
    end
    chk(busy && !req_ready, "R7 busy in done", {busy, req_ready}, 32'b10);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !tlb_fill && !fault_page && !fault_prot, "R10 flags after done",
        {busy, done, tlb_fill, fault_page, fault_prot}, 0);
  endtask

  initial begin
    int i1s [6] = '{0, 1, 2, 3, 511, 1023};
    int i2s [5] = '{0, 1, 2, 6, 1023};
    int n = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req_valid && req_ready, "R9 in reset",
        {busy, done, mem_req_valid, req_ready}, 32'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req_valid && req_ready, "R9 after reset",
        {busy, done, mem_req_valid, req_ready}, 32'b0001);
    foreach (i1s[a]) begin
      foreach (i2s[b]) begin
        for (int k = 0; k < 3; k++) begin
          walk(i1s[a], i2s[b], 3'b001 << k, n);
          n++;
        end
      end
    end
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule